// File: doc/BRIEF.md
# PLL Relock Wait Timer

After a bus-clock frequency change the system has to wait while the PLL relocks. This block times that wait. Software first stops the timer, then picks a short or a long wait, and then enables it. The counter advances only while the PLL reports that its oscillation is stable. When the count reaches the selected length, the block sets an overflow flag and emits a one-cycle resume pulse. Normal operation then continues. The overflow never causes a reset.

Two registers sit on a small word-wide bus. The control register holds the run-enable bit and the overflow flag. The wait-select register changes only when a write carries the key byte 0x55 in bits 31:24. Its encoding is inverted: a 1 selects the shortest wait and a 0 selects the longest. A third, read-only location returns the running count.

Top module: `pll_relock_wdt`

## Requirements
- R1: After reset, the run-enable bit is 0, the overflow flag is 0, the wait select is 0, the count is 0 and `resume` is low.
- R2: A write to address 0 with bit 0 = 0 clears run-enable, and the count reads 0 from the next cycle on. A write with bit 0 = 1 sets run-enable.
- R3: A write to address 1 is accepted only when bits 31:24 equal 0x55, and it stores bit 0 as the wait select. A write with any other key leaves the wait select unchanged.
- R4: With wait select = 1, `resume` rises exactly MIN_COUNT stable-PLL cycles after the enabling write.
- R5: With wait select = 0, `resume` rises exactly MAX_COUNT stable-PLL cycles after the enabling write.
- R6: While `pll_stable` is low, the count holds its value. Counting continues from that value once `pll_stable` returns high.
- R7: On overflow, `resume` is high for exactly one cycle. In that cycle the overflow flag reads 1, run-enable reads 0 and the count reads 0.
- R8: A write to address 0 with bit 1 = 0 clears the overflow flag. A write with bit 1 = 1 leaves it unchanged.
- R9: Reads are combinational. Address 0 returns {ovf at bit 1, enable at bit 0}. Address 1 returns the wait select in bit 0. Address 2 returns the count. Address 3 returns 0.
- R10: When a control write lands in the same cycle as an overflow, the overflow wins: the flag is set and run-enable is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pll_stable | input | 1 | PLL reports stable oscillation |
| resume | output | 1 | One-cycle pulse on overflow |

## Verification
Most internal state errors are visible within a few cycles:
- A wrong count shows on the address-2 readback in the very next cycle.
- A wrong wait select or key decision shows on the address-1 readback.

Some errors stay hidden until overflow:
- A wrong terminal compare, or a miscounted pause, only appears as `resume` rising too early or too late. That can be up to MAX_COUNT cycles after the fault.
- A priority error between a control write and an overflow shows in the control readback one cycle after the collision.

// File: rtl/pll_relock_wdt.sv
module pll_relock_wdt #(
  parameter int MIN_COUNT = 256,
  parameter int MAX_COUNT = 65536,
  parameter logic [7:0] KEY = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        pll_stable,
  output logic        resume
);
  localparam int CNT_W = $clog2(MAX_COUNT);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_COUNT - 1);
  localparam logic [CNT_W-1:0] MAX_LAST = CNT_W'(MAX_COUNT - 1);

  logic             en_q, ovf_q, sel_q, resume_q;
  logic [CNT_W-1:0] cnt_q;

  logic             ctrl_wr, wait_wr, stop_wr, fire;
  logic [CNT_W-1:0] last;

  assign ctrl_wr = bus_wr && bus_addr == 2'd0;
  assign wait_wr = bus_wr && bus_addr == 2'd1 && bus_wdata[31:24] == KEY;
  assign stop_wr = ctrl_wr && !bus_wdata[0];
  assign last    = sel_q ? MIN_LAST : MAX_LAST;
  assign fire    = en_q && pll_stable && cnt_q >= last;
  assign resume  = resume_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ovf_q    <= 1'b0;
      sel_q    <= 1'b0;
      resume_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      resume_q <= fire;

      if (fire)         en_q <= 1'b0;
      else if (ctrl_wr) en_q <= bus_wdata[0];

      if (fire)         ovf_q <= 1'b1;
      else if (ctrl_wr) ovf_q <= ovf_q & bus_wdata[1];

      if (wait_wr) sel_q <= bus_wdata[0];

      if (fire || !en_q || stop_wr) cnt_q <= '0;
      else if (pll_stable)          cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {30'd0, ovf_q, en_q};
      2'd1:    bus_rdata = {31'd0, sel_q};
      2'd2:    bus_rdata = 32'(cnt_q);
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/pll_relock_wdt_chk.sv
module pll_relock_wdt_chk #(
  parameter int CNT_W = 16,
  parameter logic [7:0] KEY = 8'h55
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             pll_stable,
  input logic             resume,
  input logic             en_q,
  input logic             ovf_q,
  input logic             sel_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R7

  AST_RESUME_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (ovf_q && !en_q && cnt_q == '0)); // R7

  AST_KEYLESS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && bus_wdata[31:24] != KEY) |=> $stable(sel_q)); // R3

  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !pll_stable && !bus_wr) |=> $stable(cnt_q)); // R6

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[0]) |=> (!en_q && cnt_q == '0)); // R2
endmodule

bind pll_relock_wdt pll_relock_wdt_chk #(.CNT_W(CNT_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pll_stable(pll_stable), .resume(resume),
  .en_q(en_q), .ovf_q(ovf_q), .sel_q(sel_q), .cnt_q(cnt_q)
);

// File: tb/tb_pll_relock_wdt.sv
module tb_pll_relock_wdt;
  localparam int MINC = 16;
  localparam int MAXC = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_stable = 1'b1;
  logic        resume;

  int checks = 0, failures = 0, cycles = 0;
  int m_en = 0, m_ovf = 0, m_sel = 0, m_cnt = 0, m_res = 0;

  pll_relock_wdt #(.MIN_COUNT(MINC), .MAX_COUNT(MAXC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_stable(pll_stable),
    .resume(resume));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_ovf * 2 + m_en);
      2'd1: return 32'(m_sel);
      2'd2: return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ovf = 0; m_sel = 0; m_cnt = 0; m_res = 0;
    end else begin
      int limit;
      bit over, cw;
      limit = (m_sel == 1) ? MINC : MAXC;
      over  = (m_en == 1) && pll_stable && (m_cnt + 1 >= limit);
      cw    = bus_wr && bus_addr == 2'd0;
      m_res = over;
      if (over || m_en == 0 || (cw && !bus_wdata[0])) m_cnt = 0;
      else if (pll_stable) m_cnt = m_cnt + 1;
      if (over) begin m_en = 0; m_ovf = 1; end
      else if (cw) begin
        m_en = bus_wdata[0];
        if (!bus_wdata[1]) m_ovf = 0;
      end
      if (bus_wr && bus_addr == 2'd1 && bus_wdata[31:24] == 8'h55) m_sel = bus_wdata[0];
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 rdata", bus_rdata, exp_rdata(bus_addr));
      chk("R7 resume", 32'(resume), 32'(m_res));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 2'd2;
  endtask

  task automatic wait_resume(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!resume && n < 1000);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    rd("R1 ctrl", 2'd0, 0);
    rd("R1 sel", 2'd1, 0);
    rd("R1 cnt", 2'd2, 0);
    chk("R1 resume", 32'(resume), 0);

    wr(2'd1, 32'h1200_0001);
    rd("R3 keyless", 2'd1, 0);
    wr(2'd1, 32'h5500_0001);
    rd("R3 keyed", 2'd1, 1);

    pll_stable = 1'b0;
    wr(2'd0, 32'h1);
    repeat (10) @(posedge clk); #1;
    rd("R6 no count before lock", 2'd2, 0);
    rd("R2 enabled", 2'd0, 1);
    pll_stable = 1'b1;
    wait_resume(n);
    chk("R4 min wait", 32'(n), MINC);
    rd("R7 flag", 2'd0, 2);
    @(posedge clk); #1;
    chk("R7 single pulse", 32'(resume), 0);

    wr(2'd0, 32'h2);
    rd("R8 write 1 keeps flag", 2'd0, 2);
    wr(2'd0, 32'h0);
    rd("R8 write 0 clears", 2'd0, 0);

    wr(2'd1, 32'h5500_0000);
    rd("R3 max select", 2'd1, 0);
    wr(2'd0, 32'h1);
    repeat (20) @(posedge clk); #1;
    pll_stable = 1'b0;
    rd("R6 before pause", 2'd2, 20);
    repeat (7) @(posedge clk); #1;
    rd("R6 held", 2'd2, 20);
    pll_stable = 1'b1;
    wait_resume(n);
    chk("R5 max wait", 32'(n + 20), MAXC);

    wr(2'd0, 32'h1);
    repeat (5) @(posedge clk); #1;
    wr(2'd0, 32'h0);
    rd("R2 stop clears count", 2'd2, 0);
    rd("R2 stop clears enable", 2'd0, 0);
    rd("R9 unused addr", 2'd3, 0);

    wr(2'd1, 32'h5500_0001);
    wr(2'd0, 32'h1);
    repeat (MINC - 1) @(posedge clk); #1;
    wr(2'd0, 32'h1);
    chk("R10 resume on collision", 32'(resume), 1);
    rd("R10 overflow wins", 2'd0, 2);

    repeat (3) @(posedge clk); #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule